// File: doc/BRIEF.md
# Ethernet PHY Basic Status Register Slice with Override Writes

This block is the management-side storage for the basic status register (address 1) of an Ethernet PHY, together with the override-enable bit of the extended control register (address 16). A station-management host reaches it through a parallel register port with an address, write data, a write strobe, a read strobe and combinational read data. Serial management framing, the auto-negotiation state machine and every other register are handled elsewhere.

Status bits 10 to 6 are normally read-only, but the host can change them while the override-enable bit is set. Bit 6 is one of them: it advertises that the device accepts management frames with no preamble, and it comes out of reset cleared. Bit 5 reports auto-negotiation completion. It latches high on a completion pulse from the external negotiation engine and holds until the host reads register 1. A negotiation restart does not clear it. A second read in the next cycle returns the live state.

Top module: `phy_stat_regs`

## Requirements
- R1: While reset is asserted and right after reset, reads of address 1 and address 16 both return 16'h0000.
- R2: A write to address 16 always updates the override-enable bit (bit 15). A read of address 16 returns that bit in position 15 and zeros in every other position.
- R3: While the override-enable bit is 0, a write to address 1 leaves bits 10:6 of address 1 unchanged.
- R4: While the override-enable bit is 1, a write to address 1 loads bits 10:6 from the write data. Bits 15:11 and 4:0 of address 1 always read as 0.
- R5: Bit 6 of address 1 (preamble suppression capability, 1 = frames without preamble accepted) resets to 0 and can be set or cleared only through an override write.
- R6: Bit 5 of address 1 reads 0 in every cycle in which the auto-negotiation enable input is low. A latched 1 is discarded while enable is low.
- R7: With enable high, a cycle with the completion input high makes bit 5 read 1 from the following cycle.
- R8: Once set, bit 5 stays 1 while enable remains high, even after the completion input drops, until a read of address 1.
- R9: A read of address 1 returns the latched value and clears the latch. A read in the next cycle returns the completion input as it was during the first read.
- R10: If the completion input is high in the same cycle as a read of address 1, the latch stays set and the next read returns 1.
- R11: Reads of any address other than 1 and 16 return 16'h0000. Writes to such addresses change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| re_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| an_enable_i | input | 1 | Auto-negotiation enabled |
| an_done_i | input | 1 | Auto-negotiation complete from the negotiation engine |

## Verification
The bench builds the block with its default parameters: a 5-bit address, 16-bit data, the status register at address 1, the control register at address 16, the override bit at 15, the override-writable field at bits 10:6 and the completion bit at 5. With these values, all 32 addresses are reachable, so an unimplemented address (3) can be probed for both reads and writes. They also let the bench place a completion pulse in exactly the same cycle as a status read, which is the case that decides the priority between clearing the latch and setting it.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int unsigned MGMT_AW = 5;
  localparam int unsigned MGMT_DW = 16;
  typedef logic [MGMT_AW-1:0] mgmt_addr_t;
  typedef logic [MGMT_DW-1:0] mgmt_data_t;
endpackage

// File: rtl/phy_ovr_ctrl.sv
module phy_ovr_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wbit_i,
  output logic ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ovr_o <= 1'b0;
    else if (wr_i) ovr_o <= wbit_i;
  end
endmodule

// File: rtl/phy_cw_bits.sv
module phy_cw_bits #(
  parameter int unsigned W = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         ovr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cw_o
);
  logic upd;
  assign upd = wr_i & ovr_i;  // host write lands only under override

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cw_o[i] <= RST_VAL[i];
      else if (upd) cw_o[i] <= wdata_i[i];
    end
  end
endmodule

// File: rtl/phy_anc_latch.sv
module phy_anc_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic an_en_i,
  input  logic an_done_i,
  input  logic clr_i,
  output logic anc_o
);
  logic anc_d;
  // set beats read-clear; disable beats both
  assign anc_d = an_en_i & (an_done_i | (anc_o & ~clr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) anc_o <= 1'b0;
    else         anc_o <= anc_d;
  end
endmodule

// File: rtl/phy_stat_regs.sv
module phy_stat_regs #(
  parameter int unsigned ADDR_W    = phy_mgmt_pkg::MGMT_AW,
  parameter int unsigned DATA_W    = phy_mgmt_pkg::MGMT_DW,
  parameter int unsigned STAT_ADDR = 1,
  parameter int unsigned XCTL_ADDR = 16,
  parameter int unsigned OVR_BIT   = 15,
  parameter int unsigned CW_LSB    = 6,
  parameter int unsigned CW_MSB    = 10,
  parameter int unsigned ANC_BIT   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              an_enable_i,
  input  logic              an_done_i
);
  localparam int unsigned CW_W = CW_MSB - CW_LSB + 1;

  logic            hit_stat, hit_xctl;
  logic            ovr_q, anc_q;
  logic [CW_W-1:0] cw_q;
  logic            unused_wdata;

  assign hit_stat = (addr_i == ADDR_W'(STAT_ADDR));
  assign hit_xctl = (addr_i == ADDR_W'(XCTL_ADDR));
  assign unused_wdata = ^wdata_i;

  phy_ovr_ctrl u_ovr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (we_i & hit_xctl),
    .wbit_i (wdata_i[OVR_BIT]),
    .ovr_o  (ovr_q)
  );

  phy_cw_bits #(.W(CW_W), .RST_VAL('0)) u_cw (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (we_i & hit_stat),
    .ovr_i   (ovr_q),
    .wdata_i (wdata_i[CW_MSB:CW_LSB]),
    .cw_o    (cw_q)
  );

  phy_anc_latch u_anc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .an_en_i   (an_enable_i),
    .an_done_i (an_done_i),
    .clr_i     (re_i & hit_stat),
    .anc_o     (anc_q)
  );

  always_comb begin
    rdata_o = '0;
    if (hit_stat) begin
      rdata_o[CW_MSB:CW_LSB] = cw_q;
      rdata_o[ANC_BIT]       = anc_q & an_enable_i;
    end else if (hit_xctl) begin
      rdata_o[OVR_BIT] = ovr_q;
    end
  end
endmodule

// File: rtl/phy_stat_regs_chk.sv
module phy_stat_regs_chk #(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned STAT_ADDR = 1,
  parameter int unsigned XCTL_ADDR = 16,
  parameter int unsigned OVR_BIT   = 15,
  parameter int unsigned CW_W      = 5,
  parameter int unsigned ANC_BIT   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic              re_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              an_enable_i,
  input logic              an_done_i,
  input logic              ovr_q,
  input logic              anc_q,
  input logic [CW_W-1:0]   cw_q
);
  logic at_stat, at_xctl;
  assign at_stat = (addr_i == ADDR_W'(STAT_ADDR));
  assign at_xctl = (addr_i == ADDR_W'(XCTL_ADDR));

  assert_ovr_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && at_xctl |=> ovr_q == $past(wdata_i[OVR_BIT]));

  assert_cw_locked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovr_q |=> $stable(cw_q));

  assert_anc_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !an_enable_i && at_stat |-> !rdata_o[ANC_BIT]);

  assert_anc_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    an_enable_i && an_done_i |=> anc_q);

  assert_anc_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    an_enable_i && anc_q && !(re_i && at_stat) |=> anc_q);

  assert_unimpl_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && !at_stat && !at_xctl |-> rdata_o == '0);
endmodule

bind phy_stat_regs phy_stat_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR), .XCTL_ADDR(XCTL_ADDR),
  .OVR_BIT(OVR_BIT), .CW_W(CW_MSB - CW_LSB + 1), .ANC_BIT(ANC_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .we_i(we_i), .re_i(re_i), .rdata_o(rdata_o), .an_enable_i(an_enable_i),
  .an_done_i(an_done_i), .ovr_q(ovr_q), .anc_q(anc_q), .cw_q(cw_q)
);

// File: tb/tb_phy_stat_regs.sv
`timescale 1ns/1ps
module tb_phy_stat_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [15:0] rdata;
  logic        an_en = 1'b0, an_done = 1'b0;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  phy_stat_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata),
    .an_enable_i(an_en), .an_done_i(an_done)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  a;
    logic [15:0] d;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'd1,  16'h0000, 16'h0000, 4'd1},  // R1 status after reset
    '{1'b0, 5'd16, 16'h0000, 16'h0000, 4'd1},  // R1 control after reset
    '{1'b1, 5'd1,  16'h07C0, 16'h0000, 4'd3},
    '{1'b0, 5'd1,  16'h0000, 16'h0000, 4'd3},  // R3 locked write ignored
    '{1'b1, 5'd16, 16'hFFFF, 16'h0000, 4'd2},
    '{1'b0, 5'd16, 16'h0000, 16'h8000, 4'd2},  // R2 only bit 15 kept
    '{1'b1, 5'd1,  16'hFFFF, 16'h0000, 4'd4},
    '{1'b0, 5'd1,  16'h0000, 16'h07C0, 4'd4},  // R4 field 10:6 only
    '{1'b1, 5'd1,  16'h0040, 16'h0000, 4'd5},
    '{1'b0, 5'd1,  16'h0000, 16'h0040, 4'd5},  // R5 preamble bit alone
    '{1'b1, 5'd16, 16'h0000, 16'h0000, 4'd2},
    '{1'b0, 5'd16, 16'h0000, 16'h0000, 4'd2},  // R2 override cleared
    '{1'b1, 5'd1,  16'h0780, 16'h0000, 4'd3},
    '{1'b0, 5'd1,  16'h0000, 16'h0040, 4'd3},  // R3 relocked
    '{1'b1, 5'd3,  16'hFFFF, 16'h0000, 4'd11},
    '{1'b0, 5'd3,  16'h0000, 16'h0000, 4'd11}, // R11 unimplemented read
    '{1'b0, 5'd1,  16'h0000, 16'h0040, 4'd11}  // R11 write had no effect
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic do_read(input logic [4:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; re = 1'b1;
    #1 v = rdata;
    @(posedge clk); #1 re = 1'b0;
  endtask

  task automatic rd_anc(input string req, input logic exp);
    logic [15:0] v;
    do_read(5'd1, v);
    chk(req, {15'd0, v[5]}, {15'd0, exp});
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    do_read(5'd1, v);  chk("R1 in reset status", v, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) do_write(VECS[i].a, VECS[i].d);
      else begin
        do_read(VECS[i].a, v);
        chk($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
      end
    end

    // R6: done high but negotiation disabled
    @(negedge clk); an_done = 1'b1;
    repeat (2) @(posedge clk);
    rd_anc("R6 disabled masks done", 1'b0);
    // R7
    @(negedge clk); an_en = 1'b1;
    rd_anc("R7 set on completion", 1'b1);
    // R8 holds after done drops, R9 second read is live
    @(negedge clk); an_done = 1'b0;
    repeat (3) @(posedge clk);
    rd_anc("R8 latched after drop", 1'b1);
    rd_anc("R9 second read live low", 1'b0);
    // R10: completion in the same cycle as the read
    @(negedge clk); addr = 5'd1; re = 1'b1; an_done = 1'b1;
    #1 chk("R10 read shows old value", {15'd0, rdata[5]}, 16'h0000);
    @(posedge clk); #1 re = 1'b0; an_done = 1'b0;
    rd_anc("R10 set wins over clear", 1'b1);
    rd_anc("R9 live low after clear", 1'b0);
    // R9 live high
    @(negedge clk); an_done = 1'b1;
    rd_anc("R9 first read high", 1'b1);
    rd_anc("R9 second read live high", 1'b1);
    @(negedge clk); an_done = 1'b0;
    // R6: disable discards latch
    @(negedge clk); an_en = 1'b0;
    rd_anc("R6 disabled hides latch", 1'b0);
    @(negedge clk); an_en = 1'b1;
    rd_anc("R6 latch lost after disable", 1'b0);
    // R4 full word with negotiation enabled, then R1 reset clears all
    do_write(5'd16, 16'h8000);
    do_write(5'd1, 16'hFFFF);
    do_read(5'd1, v);  chk("R4 full word", v, 16'h07C0);
    @(negedge clk); rst_n = 1'b0;
    do_read(5'd16, v); chk("R1 reset control", v, 16'h0000);
    do_read(5'd1, v);  chk("R1 reset status", v, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    do_write(5'd1, 16'h07C0);
    do_read(5'd1, v);  chk("R5 locked after reset", v, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule